// File: doc/BRIEF.md
# Clock-Domain-Crossing Register Bus Bridge

This block lets a processor running on its own clock write and read a small bank of control registers that live in an unrelated IP-core clock domain. Rather than putting a synchronizer or a small FIFO on every control register, the whole access crosses as one bundle: command, address and data are frozen in a processor-side holding register. One request toggle goes through a two-flop synchronizer to the IP side, and one acknowledge toggle comes back the same way.

On the IP side the frozen bundle is captured one destination cycle after the request edge is detected. The bridge then performs either a synchronous write into the bank or a synchronous read. For a read, the value is parked in a stable IP-side register until the acknowledge has crossed back. The processor side reports `busy` from acceptance until the acknowledge arrives. It then raises `done` for one cycle and, for reads, latches the returned word. Every bank register drives a parallel control output in the IP domain.

Top module: `cdc_reg_bridge`

## Requirements
- R1: After both resets, `cpu_busy` and `cpu_done` are low, `cpu_rdata` is zero and every bank output word on `ip_ctrl` is zero.
- R2: A strobe on `cpu_req` while `cpu_busy` is low is accepted, and `cpu_busy` is high in the following processor cycle.
- R3: A strobe on `cpu_req` while `cpu_busy` is high has no effect: no bank word changes and no extra completion is signalled.
- R4: The held command bundle (command, address, data) does not change while `cpu_busy` is high.
- R5: A write (`cpu_wr`=1) to address A stores `cpu_wdata` in bank word A. Word A appears on `ip_ctrl[A*32 +: 32]`, and no other word changes.
- R6: A read (`cpu_wr`=0) of address A places the current value of bank word A on `cpu_rdata` in the cycle `cpu_done` is high. `cpu_rdata` changes in no other cycle, and a write never changes it.
- R7: Each accepted access completes with exactly one single-cycle `cpu_done` pulse, and `cpu_busy` is low in that same cycle.
- R8: `ip_ctrl` changes only in the IP cycle following a capture, so it changes exactly once for each write whose data differs from the stored word.
- R9: Writes and reads are neither lost nor duplicated whether the IP clock is faster than, close to, or slower than the processor clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor-domain clock |
| cpu_rst | input | 1 | Processor-domain synchronous reset, active high |
| cpu_req | input | 1 | Access strobe, taken only while not busy |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Bank word select |
| cpu_wdata | input | 32 | Write data |
| cpu_busy | output | 1 | Access in flight; new strobes are ignored |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Data returned by the last completed read |
| ip_clk | input | 1 | IP-core clock |
| ip_rst | input | 1 | IP-domain synchronous reset, active high |
| ip_ctrl | output | 256 | All bank words, word i at bits [i*32 +: 32] |

## Verification
The hardest situation to reach from the ports is a strobe that lands while an earlier access is still crossing, because it must be shown to vanish without trace. The bench fires a second write, aimed at a different word with different data, during the busy window of an accepted write. Afterwards it reads that word back and counts completion pulses. The full write-then-read sweep over all eight words is repeated at three IP clock periods (faster, near-equal and much slower than the processor clock), so that the request and acknowledge edges arrive at varying phases. During the sweep the bench counts every change on `ip_ctrl` against the number of value-changing writes.

// File: rtl/cdc_bridge_pkg.sv
`timescale 1ns/1ps
package cdc_bridge_pkg;
    localparam int unsigned BR_AW   = 3;
    localparam int unsigned BR_DW   = 32;
    localparam int unsigned BR_NREG = 1 << BR_AW;

    typedef struct packed {
        logic             wr;
        logic [BR_AW-1:0] addr;
        logic [BR_DW-1:0] data;
    } br_cmd_t;

    typedef logic [BR_NREG-1:0][BR_DW-1:0] br_bank_t;
endpackage

// File: rtl/cdc_bridge_sync.sv
`timescale 1ns/1ps
module cdc_bridge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cdc_bridge_cpu_side.sv
`timescale 1ns/1ps
module cdc_bridge_cpu_side
    import cdc_bridge_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             wr,
    input  logic [BR_AW-1:0] addr,
    input  logic [BR_DW-1:0] wdata,
    input  logic             ack_sync,
    input  logic [BR_DW-1:0] ip_rdata,
    output logic             busy,
    output logic             done,
    output logic [BR_DW-1:0] rdata,
    output logic             req_tgl,
    output br_cmd_t          cmd
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic             req_tgl;
        logic             ack_seen;
        br_cmd_t          cmd;
        logic [BR_DW-1:0] rdata;
    } cpu_state_t;

    cpu_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy && (ack_sync != st_q.ack_seen)) begin
            st_d.ack_seen = ack_sync;
            st_d.busy     = 1'b0;
            st_d.done     = 1'b1;
            if (!st_q.cmd.wr) st_d.rdata = ip_rdata;
        end else if (!st_q.busy && req) begin
            st_d.cmd.wr   = wr;
            st_d.cmd.addr = addr;
            st_d.cmd.data = wdata;
            st_d.req_tgl  = ~st_q.req_tgl;
            st_d.busy     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign rdata   = st_q.rdata;
    assign req_tgl = st_q.req_tgl;
    assign cmd     = st_q.cmd;
endmodule

// File: rtl/cdc_bridge_ip_side.sv
`timescale 1ns/1ps
module cdc_bridge_ip_side
    import cdc_bridge_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_sync,
    input  br_cmd_t          cmd,
    output br_bank_t         bank,
    output logic [BR_DW-1:0] rdata,
    output logic             ack_tgl,
    output logic             cap
);
    typedef struct packed {
        logic             req_seen;
        logic             cap;
        logic             ack_tgl;
        logic [BR_DW-1:0] rdata;
        br_bank_t         bank;
    } ip_state_t;

    ip_state_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.cap = 1'b0;
        // Edge seen: wait one full cycle before sampling the held bundle.
        if (req_sync != st_q.req_seen) begin
            st_d.req_seen = req_sync;
            st_d.cap      = 1'b1;
        end
        if (st_q.cap) begin
            if (cmd.wr) st_d.bank[cmd.addr] = cmd.data;
            else        st_d.rdata          = st_q.bank[cmd.addr];
            st_d.ack_tgl = ~st_q.ack_tgl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bank    = st_q.bank;
    assign rdata   = st_q.rdata;
    assign ack_tgl = st_q.ack_tgl;
    assign cap     = st_q.cap;
endmodule

// File: rtl/cdc_reg_bridge.sv
`timescale 1ns/1ps
module cdc_reg_bridge
    import cdc_bridge_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                     cpu_clk,
    input  logic                     cpu_rst,
    input  logic                     cpu_req,
    input  logic                     cpu_wr,
    input  logic [BR_AW-1:0]         cpu_addr,
    input  logic [BR_DW-1:0]         cpu_wdata,
    output logic                     cpu_busy,
    output logic                     cpu_done,
    output logic [BR_DW-1:0]         cpu_rdata,
    input  logic                     ip_clk,
    input  logic                     ip_rst,
    output logic [BR_NREG*BR_DW-1:0] ip_ctrl
);
    logic             req_tgl_w, req_sync_w, ack_tgl_w, ack_sync_w, cap_w;
    br_cmd_t          cmd_w;
    br_bank_t         bank_w;
    logic [BR_DW-1:0] ip_rdata_w;

    cdc_bridge_cpu_side u_cpu (
        .clk(cpu_clk), .rst(cpu_rst), .req(cpu_req), .wr(cpu_wr),
        .addr(cpu_addr), .wdata(cpu_wdata), .ack_sync(ack_sync_w),
        .ip_rdata(ip_rdata_w), .busy(cpu_busy), .done(cpu_done),
        .rdata(cpu_rdata), .req_tgl(req_tgl_w), .cmd(cmd_w)
    );

    cdc_bridge_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(ip_clk), .rst(ip_rst), .din(req_tgl_w), .dout(req_sync_w)
    );

    cdc_bridge_ip_side u_ip (
        .clk(ip_clk), .rst(ip_rst), .req_sync(req_sync_w), .cmd(cmd_w),
        .bank(bank_w), .rdata(ip_rdata_w), .ack_tgl(ack_tgl_w), .cap(cap_w)
    );

    cdc_bridge_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(cpu_clk), .rst(cpu_rst), .din(ack_tgl_w), .dout(ack_sync_w)
    );

    generate
        for (genvar gi = 0; gi < BR_NREG; gi++) begin : g_out
            assign ip_ctrl[gi*BR_DW +: BR_DW] = bank_w[gi];
        end
    endgenerate
endmodule

// File: rtl/cdc_bridge_chk.sv
`timescale 1ns/1ps
module cdc_bridge_chk
    import cdc_bridge_pkg::*;
(
    input logic                     cpu_clk,
    input logic                     cpu_rst,
    input logic                     cpu_req,
    input logic                     cpu_busy,
    input logic                     cpu_done,
    input logic [BR_DW-1:0]         cpu_rdata,
    input br_cmd_t                  held_cmd,
    input logic                     ip_clk,
    input logic                     ip_rst,
    input logic                     ip_cap,
    input logic [BR_NREG*BR_DW-1:0] ip_ctrl
);
    p_accept_r2: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        (cpu_req && !cpu_busy) |=> cpu_busy);

    p_hold_stable_r4: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        cpu_busy |=> $stable(held_cmd));

    p_rdata_quiet_r6: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        !cpu_done |-> $stable(cpu_rdata));

    p_done_ends_busy_r7: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        cpu_done |-> $fell(cpu_busy));

    p_done_single_r7: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        cpu_done |=> !cpu_done);

    p_ctrl_only_on_capture_r8: assert property (@(posedge ip_clk) disable iff (ip_rst)
        !ip_cap |=> $stable(ip_ctrl));
endmodule

bind cdc_reg_bridge cdc_bridge_chk u_chk (
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .cpu_req(cpu_req),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .held_cmd(cmd_w), .ip_clk(ip_clk), .ip_rst(ip_rst),
    .ip_cap(cap_w), .ip_ctrl(ip_ctrl)
);

// File: tb/cdc_reg_bridge_tb.sv
`timescale 1ns/1ps
module cdc_reg_bridge_tb;
    logic         cpu_clk = 0, ip_clk = 0;
    logic         cpu_rst = 1, ip_rst = 1;
    logic         cpu_req = 0, cpu_wr = 0;
    logic [2:0]   cpu_addr = 0;
    logic [31:0]  cpu_wdata = 0;
    logic         cpu_busy, cpu_done;
    logic [31:0]  cpu_rdata;
    logic [255:0] ip_ctrl;

    int ip_half = 7;
    int total = 0, bad = 0;
    int done_cnt = 0, exp_done = 0;
    int chg_cnt = 0, exp_chg = 0;
    logic [31:0]  mdl [8];
    logic [31:0]  last_rd = 0;
    logic [255:0] prev_ctrl = '0;
    bit finished = 0;

    always #10 cpu_clk = ~cpu_clk;
    always #(ip_half) ip_clk = ~ip_clk;

    cdc_reg_bridge u_dut (
        .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .ip_clk(ip_clk),
        .ip_rst(ip_rst), .ip_ctrl(ip_ctrl)
    );

    always @(negedge cpu_clk) if (!cpu_rst && cpu_done === 1'b1) done_cnt++;
    always @(negedge ip_clk) begin
        if (!ip_rst && ip_ctrl !== prev_ctrl) chg_cnt++;
        prev_ctrl = ip_ctrl;
    end

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic start(input logic w, input logic [2:0] a, input logic [31:0] d);
        @(negedge cpu_clk);
        cpu_req = 1; cpu_wr = w; cpu_addr = a; cpu_wdata = d;
        @(negedge cpu_clk);
        cpu_req = 0;
        chk(cpu_busy === 1'b1, "R2 busy after accept", cpu_busy, 1);
        exp_done++;
    endtask

    task automatic wait_done;
        int n = 0;
        while (cpu_done !== 1'b1 && n < 5000) begin
            @(negedge cpu_clk);
            n++;
        end
        chk(n < 5000, "R9 completion arrives", n, 0);
        chk(cpu_busy === 1'b0, "R7 busy low with done", cpu_busy, 0);
    endtask

    task automatic post_done;
        @(negedge cpu_clk);
        chk(cpu_done === 1'b0, "R7 done is one cycle", cpu_done, 0);
    endtask

    task automatic do_write(input logic [2:0] a, input logic [31:0] d);
        start(1, a, d);
        wait_done();
        if (mdl[a] !== d) exp_chg++;
        mdl[a] = d;
        chk(ip_ctrl[a*32 +: 32] === d, "R5 word written", ip_ctrl[a*32 +: 32], d);
        chk(cpu_rdata === last_rd, "R6 write leaves rdata", cpu_rdata, last_rd);
        post_done();
    endtask

    task automatic do_read(input logic [2:0] a);
        start(0, a, 32'h0);
        wait_done();
        chk(cpu_rdata === mdl[a], "R6 read value", cpu_rdata, mdl[a]);
        last_rd = mdl[a];
        post_done();
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < 8; i++)
            chk(ip_ctrl[i*32 +: 32] === mdl[i], tag, ip_ctrl[i*32 +: 32], mdl[i]);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mdl[i] = 0;
        repeat (5) @(negedge cpu_clk);
        cpu_rst = 0; ip_rst = 0;
        repeat (3) @(negedge cpu_clk);
        // R1 reset state
        chk(cpu_busy === 1'b0, "R1 busy after reset", cpu_busy, 0);
        chk(cpu_done === 1'b0, "R1 done after reset", cpu_done, 0);
        chk(cpu_rdata === 32'h0, "R1 rdata after reset", cpu_rdata, 0);
        chk(ip_ctrl === '0, "R1 bank after reset", ip_ctrl, 0);

        // R9 sweep at three clock ratios
        for (int k = 0; k < 3; k++) begin
            ip_half = (k == 0) ? 7 : (k == 1) ? 11 : 53;
            repeat (4) @(negedge cpu_clk);
            for (int i = 0; i < 8; i++)
                do_write(i[2:0], 32'hA500_0000 ^ (i * 32'h0101_0101) ^ (k << 20));
            check_bank("R5 bank after sweep");
            for (int i = 7; i >= 0; i--) do_read(i[2:0]);
            do_write(3'd0, 32'hFFFF_FFFF);
            do_read(3'd0);
            do_write(3'd0, 32'h0);
            do_read(3'd0);
            do_write(3'd0, 32'h0);   // same value: no change on ip_ctrl
        end

        // R3 strobe while busy is ignored
        ip_half = 11;
        start(1, 3'd2, 32'h1234_5678);
        cpu_req = 1; cpu_wr = 1; cpu_addr = 3'd5; cpu_wdata = ~mdl[5];
        @(negedge cpu_clk);
        cpu_req = 0;
        wait_done();
        if (mdl[2] !== 32'h1234_5678) exp_chg++;
        mdl[2] = 32'h1234_5678;
        post_done();
        repeat (30) @(negedge cpu_clk);
        chk(ip_ctrl[5*32 +: 32] === mdl[5], "R3 ignored write absent", ip_ctrl[5*32 +: 32], mdl[5]);
        chk(done_cnt == exp_done, "R3 no extra completion", done_cnt, exp_done);
        do_read(3'd5);
        do_read(3'd2);
        check_bank("R3 bank intact");

        repeat (30) @(negedge cpu_clk);
        chk(done_cnt == exp_done, "R7 one done per access", done_cnt, exp_done);
        chk(chg_cnt == exp_chg, "R8 ctrl change count", chg_cnt, exp_chg);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #3_000_000;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R9 watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule